// File: doc/BRIEF.md
# Radix-4 Booth Signed Multiplier

This block multiplies two signed two's-complement operands and returns the full-width signed product. It is meant to sit inside a filter tap or any other datapath that needs a compact signed multiply. The multiplier operand (`op_b`) is split into overlapping three-bit windows. Each window becomes one Booth digit, and the digit selects a multiple of the multiplicand (`op_a`): zero, plus or minus one times it, or plus or minus two times it. Because one digit covers two multiplier bits, a 16-bit operand yields eight partial-product rows. A bit-serial array would need sixteen.

A negative digit does not build a two's-complement multiple in the row itself. The row holds the inverted multiple, and a single 1 is owed at that row's lowest weight. Each row is sign-extended to the product width and shifted left by twice its index. All rows and all owed ones are then added together. The digit is an enumerated type with the values `DIG_ZERO`, `DIG_P1`, `DIG_P2`, `DIG_M1` and `DIG_M2`. It is a pure function of its window, so there are no transitions between digits.

The parameter `STAGES` picks the pipeline depth: 0, 1 or 2 register stages. With 0 stages the block is fully combinational. With 1 stage only the product is registered. With 2 stages the partial-product rows are registered before the adder as well. `valid_out` follows `valid_in` delayed by exactly `STAGES` cycles. One new operand pair is accepted every cycle.

Top module: `booth_mul_r4`

## Requirements
- R1: When `valid_out` is high, `product` equals the exact signed product of the `op_a`/`op_b` pair that was presented with `valid_in` high `STAGES` cycles earlier. The check covers every operand value.
- R2: Each window (b[2i+1], b[2i], b[2i-1]) of `op_b` is recoded with b[-1] = 0. The mapping is 000→0, 001→+1, 010→+1, 011→+2, 100→−2, 101→−1, 110→−1, 111→0. As a result, multipliers made only of repeated 01 or 10 bit pairs (0x5555, 0xAAAA) and single powers of two give exact products.
- R3: −32768 × −32768 yields 0x40000000. The other products involving −32768 are also exact.
- R4: If either operand is zero, `product` is zero.
- R5: `valid_out` equals `valid_in` delayed by exactly `STAGES` cycles (default 2).
- R6: After `rst_n` is released, `valid_out` stays low until the first accepted pair has travelled the whole pipeline.
- R7: A new operand pair can be applied every cycle. Pairs issued back to back, and pairs with idle cycles between them, each produce their own result in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_in | input | 1 | Operand pair is valid this cycle |
| op_a | input | 16 | Multiplicand, signed |
| op_b | input | 16 | Multiplier, signed (Booth-recoded) |
| valid_out | output | 1 | Product is valid this cycle |
| product | output | 32 | Signed product |

## Verification
The bench first crosses sixteen edge values against each other: zero, ±1, ±2, the extremes, and alternating bit patterns. This separates digit-selection errors from sign-extension errors. Next, a full sweep of every multiplier value against an odd negative multiplicand reaches every possible window in every row. This exposes any wrong entry in the recoding table or a missing owed one. A random phase with irregular gaps in `valid_in` separates latency errors from data errors.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;

    // One recoded radix-4 digit; the value is the multiple of op_a selected.
    typedef enum logic [2:0] {
        DIG_ZERO = 3'd0,
        DIG_P1   = 3'd1,
        DIG_P2   = 3'd2,
        DIG_M1   = 3'd5,
        DIG_M2   = 3'd6
    } booth_digit_e;

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
    import booth_mul_pkg::*;
(
    input  logic [2:0]   window,
    output booth_digit_e digit
);

    // window = {b[2i+1], b[2i], b[2i-1]}
    always_comb begin
        unique case (window)
            3'b000:  digit = DIG_ZERO;
            3'b001:  digit = DIG_P1;
            3'b010:  digit = DIG_P1;
            3'b011:  digit = DIG_P2;
            3'b100:  digit = DIG_M2;
            3'b101:  digit = DIG_M1;
            3'b110:  digit = DIG_M1;
            default: digit = DIG_ZERO;
        endcase
    end

endmodule

// File: rtl/booth_pp_row.sv
module booth_pp_row
    import booth_mul_pkg::*;
#(
    parameter int OP_W = 16,
    localparam int RW = OP_W + 1
) (
    input  logic [OP_W-1:0] mcand,
    input  booth_digit_e    digit,
    output logic [RW-1:0]   row,
    output logic            neg
);

    logic [RW-1:0] one_x;
    logic [RW-1:0] two_x;

    assign one_x = {mcand[OP_W-1], mcand};
    assign two_x = {mcand, 1'b0};

    // Negative digits invert the multiple; the +1 is owed via neg.
    always_comb begin
        unique case (digit)
            DIG_P1:  begin row = one_x;  neg = 1'b0; end
            DIG_P2:  begin row = two_x;  neg = 1'b0; end
            DIG_M1:  begin row = ~one_x; neg = 1'b1; end
            DIG_M2:  begin row = ~two_x; neg = 1'b1; end
            default: begin row = '0;     neg = 1'b0; end
        endcase
    end

endmodule

// File: rtl/booth_accum.sv
module booth_accum #(
    parameter int NROWS = 8,
    parameter int RW    = 17,
    parameter int PW    = 32
) (
    input  logic [NROWS-1:0][RW-1:0] rows,
    input  logic [NROWS-1:0]         negs,
    output logic [PW-1:0]            sum
);

    always_comb begin
        logic [PW-1:0] acc;
        logic [PW-1:0] ext;
        acc = '0;
        for (int i = 0; i < NROWS; i++) begin
            ext = {{(PW-RW){rows[i][RW-1]}}, rows[i]};
            acc = acc + (ext << (2*i));
            acc = acc + (PW'(negs[i]) << (2*i));
        end
        sum = acc;
    end

endmodule

// File: rtl/booth_mul_r4.sv
module booth_mul_r4
    import booth_mul_pkg::*;
#(
    parameter int OP_W   = 16,
    parameter int STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   valid_in,
    input  logic [OP_W-1:0]        op_a,
    input  logic [OP_W-1:0]        op_b,
    output logic                   valid_out,
    output logic [2*OP_W-1:0]      product
);

    localparam int NROWS = OP_W / 2;
    localparam int RW    = OP_W + 1;
    localparam int PW    = 2 * OP_W;

    logic [OP_W:0]             b_ext;
    booth_digit_e              digits [NROWS];
    logic [NROWS-1:0][RW-1:0]  rows_c;
    logic [NROWS-1:0]          negs_c;
    logic [NROWS-1:0][RW-1:0]  rows_s;
    logic [NROWS-1:0]          negs_s;
    logic                      vld_s;
    logic [PW-1:0]             sum_c;

    assign b_ext = {op_b, 1'b0};

    for (genvar i = 0; i < NROWS; i++) begin : g_row
        booth_recoder u_rec (
            .window (b_ext[2*i+2 : 2*i]),
            .digit  (digits[i])
        );
        booth_pp_row #(.OP_W(OP_W)) u_pp (
            .mcand (op_a),
            .digit (digits[i]),
            .row   (rows_c[i]),
            .neg   (negs_c[i])
        );
    end

    // Optional register between row generation and summation.
    if (STAGES >= 2) begin : g_row_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rows_s <= '0;
                negs_s <= '0;
                vld_s  <= 1'b0;
            end else begin
                rows_s <= rows_c;
                negs_s <= negs_c;
                vld_s  <= valid_in;
            end
        end
    end else begin : g_row_pass
        assign rows_s = rows_c;
        assign negs_s = negs_c;
        assign vld_s  = valid_in;
    end

    booth_accum #(.NROWS(NROWS), .RW(RW), .PW(PW)) u_acc (
        .rows (rows_s),
        .negs (negs_s),
        .sum  (sum_c)
    );

    // Optional output register.
    if (STAGES >= 1) begin : g_out_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                product   <= '0;
                valid_out <= 1'b0;
            end else begin
                product   <= sum_c;
                valid_out <= vld_s;
            end
        end
    end else begin : g_out_pass
        assign product   = sum_c;
        assign valid_out = vld_s;
    end

endmodule

// File: rtl/booth_mul_r4_chk.sv
module booth_mul_r4_chk #(
    parameter int OP_W   = 16,
    parameter int STAGES = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                valid_in,
    input logic [OP_W-1:0]     op_a,
    input logic [OP_W-1:0]     op_b,
    input logic                valid_out,
    input logic [2*OP_W-1:0]   product
);

    localparam int PW = 2 * OP_W;
    localparam logic [PW-1:0] MIN_SQ = PW'(1) << (PW - 2);
    localparam logic [OP_W-1:0] MIN_OP = {1'b1, {(OP_W-1){1'b0}}};

    logic signed [PW-1:0] ref_now;
    logic                 zero_now, minsq_now;
    logic [PW-1:0]        ref_d1, ref_d2, exp_ref;
    logic                 v_d1, v_d2, exp_v;
    logic                 z_d1, z_d2, exp_z;
    logic                 m_d1, m_d2, exp_m;
    logic [1:0]           age;

    assign ref_now   = $signed({{OP_W{op_a[OP_W-1]}}, op_a}) *
                       $signed({{OP_W{op_b[OP_W-1]}}, op_b});
    assign zero_now  = (op_a == '0) || (op_b == '0);
    assign minsq_now = (op_a == MIN_OP) && (op_b == MIN_OP);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_d1 <= '0; ref_d2 <= '0;
            v_d1 <= 1'b0; v_d2 <= 1'b0;
            z_d1 <= 1'b0; z_d2 <= 1'b0;
            m_d1 <= 1'b0; m_d2 <= 1'b0;
            age  <= 2'd0;
        end else begin
            ref_d1 <= ref_now; ref_d2 <= ref_d1;
            v_d1 <= valid_in;  v_d2 <= v_d1;
            z_d1 <= zero_now;  z_d2 <= z_d1;
            m_d1 <= minsq_now; m_d2 <= m_d1;
            if (age != 2'd3) age <= age + 2'd1;
        end
    end

    assign exp_ref = (STAGES == 0) ? ref_now   : (STAGES == 1) ? ref_d1 : ref_d2;
    assign exp_v   = (STAGES == 0) ? valid_in  : (STAGES == 1) ? v_d1   : v_d2;
    assign exp_z   = (STAGES == 0) ? zero_now  : (STAGES == 1) ? z_d1   : z_d2;
    assign exp_m   = (STAGES == 0) ? minsq_now : (STAGES == 1) ? m_d1   : m_d2;

    AST_EXACT_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_out && int'(age) >= STAGES) |-> (product == exp_ref)); // R1

    AST_MIN_SQUARE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_out && exp_m && int'(age) >= STAGES) |-> (product == MIN_SQ)); // R3

    AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_out && exp_z && int'(age) >= STAGES) |-> (product == '0)); // R4

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(age) >= STAGES) |-> (valid_out == exp_v)); // R5

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(age) < STAGES) |-> !valid_out); // R6

endmodule

bind booth_mul_r4 booth_mul_r4_chk #(.OP_W(OP_W), .STAGES(STAGES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_in  (valid_in),
    .op_a      (op_a),
    .op_b      (op_b),
    .valid_out (valid_out),
    .product   (product)
);

// File: tb/booth_mul_r4_test.sv
module booth_mul_r4_test;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic        valid_out;
    logic [31:0] product;

    int checks = 0;
    int errors = 0;
    int step_n = 0;
    logic        hv [4];
    logic [31:0] hp [4];
    string       ht [4];
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    booth_mul_r4 #(.OP_W(16), .STAGES(LAT)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_in  (valid_in),
        .op_a      (op_a),
        .op_b      (op_b),
        .valid_out (valid_out),
        .product   (product)
    );

    function automatic logic [31:0] ref_mul(input logic [15:0] a, input logic [15:0] b);
        logic signed [31:0] sa, sb;
        sa = $signed({{16{a[15]}}, a});
        sb = $signed({{16{b[15]}}, b});
        return sa * sb;
    endfunction

    // Apply one pair on a falling edge, then compare the output that
    // belongs to the pair issued LAT steps earlier.
    task automatic step(input logic v, input logic [15:0] a, input logic [15:0] b,
                        input string tag);
        int k;
        @(negedge clk);
        valid_in = v;
        op_a = a;
        op_b = b;
        hv[step_n % 4] = v;
        hp[step_n % 4] = ref_mul(a, b);
        ht[step_n % 4] = tag;
        #1;
        checks++;
        if (step_n < LAT) begin
            if (valid_out !== 1'b0) begin
                errors++;
                $display("FAIL R6: valid_out=%b expected 0 at step %0d", valid_out, step_n);
            end
        end else begin
            k = (step_n - LAT) % 4;
            if (valid_out !== hv[k]) begin
                errors++;
                $display("FAIL R5: valid_out=%b expected %b at step %0d", valid_out, hv[k], step_n);
            end else if (hv[k]) begin
                checks++;
                if (product !== hp[k]) begin
                    errors++;
                    $display("FAIL %s: product=%h expected %h", ht[k], product, hp[k]);
                end
            end
        end
        step_n++;
    endtask

    task automatic flush();
        for (int i = 0; i < LAT + 1; i++) step(1'b0, 16'h0, 16'h0, "R5");
    endtask

    initial begin
        logic [15:0] edges [16];
        edges = '{16'h0000, 16'h0001, 16'h0002, 16'hFFFF, 16'hFFFE, 16'h7FFF,
                  16'h8000, 16'h8001, 16'h5555, 16'hAAAA, 16'h3333, 16'hCCCC,
                  16'h0100, 16'h4000, 16'h00FF, 16'hFF00};
        for (int i = 0; i < 4; i++) begin hv[i] = 1'b0; hp[i] = '0; ht[i] = "R6"; end

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R6: first LAT samples after reset must show no valid output.
        // R3: most negative squared is 0x40000000.
        step(1'b1, 16'h8000, 16'h8000, "R3");
        step(1'b1, 16'h8000, 16'h7FFF, "R3");
        step(1'b1, 16'h7FFF, 16'h8000, "R3");
        step(1'b1, 16'h8000, 16'hFFFF, "R3");
        // R4: zero on either side.
        step(1'b1, 16'h0000, 16'h8000, "R4");
        step(1'b1, 16'h7FFF, 16'h0000, "R4");
        step(1'b1, 16'h0000, 16'h0000, "R4");
        flush();

        // R1, R2: full cross of edge values, back to back (R7).
        for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++)
                step(1'b1, edges[i], edges[j], "R1");
        flush();

        // R2: single powers of two as multiplier.
        for (int s = 0; s < 16; s++) step(1'b1, 16'h9ABD, 16'(1) << s, "R2");
        flush();

        // R2, R1: every multiplier value, with periodic idle cycles (R7).
        for (int b = 0; b < 65536; b++)
            step((b % 7) != 3, 16'hAAAB, 16'(b), "R2");
        flush();

        // R7: random operands with irregular valid.
        for (int n = 0; n < 3000; n++) begin
            logic [15:0] ra, rb;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ra = lfsr;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            rb = lfsr;
            step(ra[0] | rb[1], ra, rb, "R7");
        end
        flush();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule